// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block is a synchronous host-side controller for a successive-approximation converter with a parallel data bus. It drives the converter's active-low select, start, read and shutdown lines and watches the converter's active-low busy flag. When a requester asks for a sample, the block first asserts select and waits a programmable setup time. It then pulls the start line low for a short, programmable number of cycles, so that the release edge comes early in the conversion and does not disturb the bit decisions. After that it waits for busy to rise. On that edge it registers the data word and presents it with a one-cycle valid strobe. If busy never rises, a timeout raises an error pulse and the block returns to idle.

Power-down is requested from idle. The block first drives select to the level that chooses the shutdown depth: select low for the light (nap) mode, select high for the deep (sleep) mode. One cycle later it drops the shutdown line. A wake request raises shutdown again. The block then holds off new conversions for a mode-dependent number of cycles, which covers the reference settling that the deep mode needs. Every delay is a clock-cycle count set by a parameter.

The state machine has seven states:
- IDLE: ready.
- SETUP: select low.
- PULSE: start low.
- WAIT: read low, waiting for busy.
- PD_SEL: select set to the mode level.
- DOWN: shutdown low.
- WAKE: wake-up delay.

The transitions are:
- IDLE→SETUP on a conversion request.
- IDLE→PD_SEL on a power-down request.
- SETUP→PULSE when the setup count expires.
- PULSE→WAIT when the pulse count expires.
- WAIT→IDLE on the busy rising edge (capture).
- WAIT→IDLE on timeout (error).
- PD_SEL→DOWN after one cycle.
- DOWN→WAKE on a wake request.
- WAKE→IDLE when the wake count expires.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `adc_cs_n`, `adc_start_n`, `adc_rd_n` and `adc_shdn_n` are all 1, `ready` is 1, and `dout_valid`, `conv_err` and `powered_down` are 0.
- R2: A `conv_req` sampled in idle drives `adc_cs_n` low with `adc_start_n` high for exactly SETUP_CYC cycles before `adc_start_n` falls.
- R3: `adc_start_n` stays low for exactly START_LOW_CYC cycles per conversion, and it is only ever low while `adc_cs_n` is low.
- R4: While a conversion is in progress, further `conv_req` and `pd_req` have no effect: each accepted request gives exactly one falling edge on `adc_start_n` and `adc_shdn_n` stays 1.
- R5: While waiting, `adc_rd_n` is 0. On the first cycle that `adc_busy_n` is seen 1 after being 0, `adc_data` is registered. In the next cycle `dout` holds that word, `dout_valid` is 1 for exactly that one cycle, and `ready` is 1.
- R6: `ready` is 0 from the cycle after an accepted `conv_req` until the cycle in which `dout_valid` or `conv_err` is 1.
- R7: If busy does not rise within TIMEOUT_CYC cycles of waiting (that is, `adc_rd_n` is low for TIMEOUT_CYC cycles), the block gives a one-cycle `conv_err` pulse with `dout_valid` 0, returns to idle with `adc_cs_n` 1, and produces no data strobe.
- R8: A `pd_req` in idle first drives `adc_cs_n` to the value of `pd_deep` (1 selects sleep, 0 selects nap) with `adc_shdn_n` still 1. In the next cycle `adc_shdn_n` falls and `powered_down` becomes 1, and `adc_cs_n` keeps its level for as long as `adc_shdn_n` is 0. A `conv_req` in power-down has no effect.
- R9: A `wake_req` in power-down raises `adc_shdn_n`. `ready` then stays 0 for exactly NAP_WAKE_CYC cycles (after nap) or SLEEP_WAKE_CYC cycles (after sleep). A `conv_req` during that delay causes no start pulse.
- R10: When `conv_req` and `pd_req` are both 1 in idle, the conversion is taken and the power-down request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_req | input | 1 | Request one conversion (level, sampled in idle) |
| pd_req | input | 1 | Request power-down (sampled in idle) |
| pd_deep | input | 1 | Power-down depth: 1 sleep, 0 nap |
| wake_req | input | 1 | Leave power-down |
| adc_busy_n | input | 1 | Converter busy flag, low while converting |
| adc_data | input | DATA_W | Converter parallel data bus |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_start_n | output | 1 | Conversion start, active low |
| adc_rd_n | output | 1 | Converter read enable, active low |
| adc_shdn_n | output | 1 | Converter shutdown, active low |
| ready | output | 1 | Block idle and able to take a request |
| dout | output | DATA_W | Last captured data word |
| dout_valid | output | 1 | One-cycle strobe for a new word in `dout` |
| conv_err | output | 1 | One-cycle conversion timeout pulse |
| powered_down | output | 1 | Converter held in shutdown |

## Verification
A wrong state in this block shows up at the converter pins in the same cycle, because every pin is decoded straight from the state register. A stuck or skipped state therefore shows as a wrong setup length, a wrong start pulse width or a shutdown line at the wrong level. A counter that is loaded with the wrong value moves the next edge by a predictable number of cycles. The bench therefore measures each window exactly: select-to-start, start width, waiting length up to the timeout, and wake-up length in both modes.

A missed or doubled busy edge shows within one conversion, as a missing strobe, a doubled strobe or a wrong captured word. Requests sent during busy, power-down and wake-up are checked by counting start edges.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_WAIT,
        ST_PD_SEL,
        ST_DOWN,
        ST_WAKE
    } seq_state_e;

    function automatic int cyc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // Once expired the count stays expired until reloaded
    p_hold_expired_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/seq_capture.sv
module seq_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              err_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              conv_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
            conv_err   <= 1'b0;
        end else begin
            dout_valid <= cap_en;
            conv_err   <= err_en;
            if (cap_en) begin
                dout <= din;
            end
        end
    end

    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

    p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_err |-> !dout_valid);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int SETUP_CYC      = 5,
    parameter int START_LOW_CYC  = 25,
    parameter int NAP_WAKE_CYC   = 250,
    parameter int SLEEP_WAKE_CYC = 40_000_000,
    parameter int TIMEOUT_CYC    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_req,
    input  logic              pd_req,
    input  logic              pd_deep,
    input  logic              wake_req,
    input  logic              adc_busy_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_cs_n,
    output logic              adc_start_n,
    output logic              adc_rd_n,
    output logic              adc_shdn_n,
    output logic              ready,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              conv_err,
    output logic              powered_down
);
    localparam int CNT_MAX = cyc_max(cyc_max(cyc_max(SETUP_CYC, START_LOW_CYC),
                                             cyc_max(NAP_WAKE_CYC, SLEEP_WAKE_CYC)),
                                     TIMEOUT_CYC);
    localparam int TW = $clog2(CNT_MAX + 1);

    seq_state_e state, state_nxt;
    logic          deep_q;
    logic          busy_q;
    logic          busy_rise;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          cap_en;
    logic          err_en;

    // State register, latched mode and busy history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            deep_q <= 1'b0;
            busy_q <= 1'b1;
        end else begin
            state  <= state_nxt;
            busy_q <= adc_busy_n;
            if (state == ST_IDLE && !conv_req && pd_req) begin
                deep_q <= pd_deep;
            end
        end
    end

    assign busy_rise = adc_busy_n && !busy_q;

    // Next state and counter loads
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cap_en    = 1'b0;
        err_en    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (conv_req) begin
                    state_nxt = ST_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(SETUP_CYC - 1);
                end else if (pd_req) begin
                    state_nxt = ST_PD_SEL;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    state_nxt = ST_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(START_LOW_CYC - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    state_nxt = ST_WAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(TIMEOUT_CYC - 1);
                end
            end
            ST_WAIT: begin
                if (busy_rise) begin
                    state_nxt = ST_IDLE;
                    cap_en    = 1'b1;
                end else if (tmr_zero) begin
                    state_nxt = ST_IDLE;
                    err_en    = 1'b1;
                end
            end
            ST_PD_SEL: begin
                state_nxt = ST_DOWN;
            end
            ST_DOWN: begin
                if (wake_req) begin
                    state_nxt = ST_WAKE;
                    tmr_load  = 1'b1;
                    tmr_val   = deep_q ? TW'(SLEEP_WAKE_CYC - 1) : TW'(NAP_WAKE_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (tmr_zero) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Pin and status decode
    always_comb begin
        adc_cs_n     = 1'b1;
        adc_start_n  = 1'b1;
        adc_rd_n     = 1'b1;
        adc_shdn_n   = 1'b1;
        ready        = 1'b0;
        powered_down = 1'b0;
        unique case (state)
            ST_IDLE:   ready = 1'b1;
            ST_SETUP:  adc_cs_n = 1'b0;
            ST_PULSE: begin
                adc_cs_n    = 1'b0;
                adc_start_n = 1'b0;
            end
            ST_WAIT: begin
                adc_cs_n = 1'b0;
                adc_rd_n = 1'b0;
            end
            ST_PD_SEL: adc_cs_n = deep_q;
            ST_DOWN: begin
                adc_cs_n     = deep_q;
                adc_shdn_n   = 1'b0;
                powered_down = 1'b1;
            end
            ST_WAKE: ;
            default: ;
        endcase
    end

    seq_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    seq_capture #(.DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .err_en     (err_en),
        .din        (adc_data),
        .dout       (dout),
        .dout_valid (dout_valid),
        .conv_err   (conv_err)
    );

    p_start_under_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_start_n |-> !adc_cs_n);

    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (adc_start_n && adc_shdn_n && !ready));

    p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_shdn_n |-> $stable(adc_cs_n));

    p_wake_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> (!ready && adc_shdn_n && adc_start_n));

    p_strobe_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid || conv_err) |-> ready);

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    localparam int DW = 12;
    localparam int SU = 3;
    localparam int SL = 4;
    localparam int NW = 10;
    localparam int SW = 37;
    localparam int TO = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_req = 1'b0, pd_req = 1'b0, pd_deep = 1'b0, wake_req = 1'b0;
    logic          adc_busy_n = 1'b1;
    logic [DW-1:0] adc_data = '0;
    logic          adc_cs_n, adc_start_n, adc_rd_n, adc_shdn_n;
    logic          ready, dout_valid, conv_err, powered_down;
    logic [DW-1:0] dout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // responder and monitor state
    bit resp_en = 1;
    int resp_len = 6;
    logic [DW-1:0] resp_word = '0;
    int resp_cnt = 0;
    logic rs_q = 1'b1;
    logic st_q = 1'b1;
    int falls = 0, low_run = 0, pulse_w = 0, cs_run = 0, setup_seen = 0, cs_bad = 0;
    int vcount = 0, vrun = 0, vmax = 0;

    always #2 clk = ~clk;

    adc_seq_ctrl #(
        .DATA_W(DW), .SETUP_CYC(SU), .START_LOW_CYC(SL),
        .NAP_WAKE_CYC(NW), .SLEEP_WAKE_CYC(SW), .TIMEOUT_CYC(TO)
    ) i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .pd_req(pd_req),
        .pd_deep(pd_deep), .wake_req(wake_req), .adc_busy_n(adc_busy_n),
        .adc_data(adc_data), .adc_cs_n(adc_cs_n), .adc_start_n(adc_start_n),
        .adc_rd_n(adc_rd_n), .adc_shdn_n(adc_shdn_n), .ready(ready), .dout(dout),
        .dout_valid(dout_valid), .conv_err(conv_err), .powered_down(powered_down)
    );

    // behavioural converter: busy low for resp_len cycles after a selected start fall
    always @(negedge clk) begin
        if (resp_cnt > 0) begin
            resp_cnt = resp_cnt - 1;
            if (resp_cnt == 0) begin
                adc_data   = resp_word;
                adc_busy_n = 1'b1;
            end
        end else if (rs_q && !adc_start_n && !adc_cs_n && resp_en) begin
            adc_busy_n = 1'b0;
            resp_cnt   = resp_len;
        end
        rs_q = adc_start_n;
    end

    // pin monitor
    always @(negedge clk) begin
        if (st_q && !adc_start_n) begin
            falls      = falls + 1;
            setup_seen = cs_run;
        end
        if (!adc_start_n) low_run = low_run + 1;
        if (adc_start_n && !st_q) begin
            pulse_w = low_run;
            low_run = 0;
        end
        if (!adc_start_n && adc_cs_n) cs_bad = cs_bad + 1;
        if (adc_cs_n) cs_run = 0;
        else if (adc_start_n) cs_run = cs_run + 1;
        st_q = adc_start_n;
        if (dout_valid) begin
            vcount = vcount + 1;
            vrun   = vrun + 1;
        end else begin
            vrun = 0;
        end
        if (vrun > vmax) vmax = vrun;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_conv(input int len, input logic [DW-1:0] word, input bit spam);
        int f0, n, rdy_bad, shdn_bad;
        logic [DW-1:0] got;
        resp_len  = len;
        resp_word = word;
        resp_en   = 1;
        f0 = falls;
        conv_req = 1'b1;
        if (spam) begin
            pd_req  = 1'b1;
            pd_deep = 1'b1;
        end
        step();
        if (!spam) conv_req = 1'b0;
        n = 0; rdy_bad = 0; shdn_bad = 0;
        while (!dout_valid && n < 200) begin
            if (ready) rdy_bad++;
            if (!adc_shdn_n) shdn_bad++;
            step();
            n++;
        end
        conv_req = 1'b0;
        pd_req   = 1'b0;
        got = dout;
        chk(dout_valid == 1'b1, "R5 valid strobe seen", dout_valid, 1);
        chk(got == word, "R5 captured word", got, word);
        chk(ready == 1'b1, "R6 ready with strobe", ready, 1);
        chk(rdy_bad == 0, "R6 ready low during conversion", rdy_bad, 0);
        chk(falls - f0 == 1, "R4 start edges per request", falls - f0, 1);
        chk(shdn_bad == 0, "R10 shutdown untouched in conversion", shdn_bad, 0);
        chk(pulse_w == SL, "R3 start low width", pulse_w, SL);
        chk(setup_seen == SU, "R2 select-to-start setup", setup_seen, SU);
        step();
        chk(dout_valid == 1'b0, "R5 strobe single cycle", dout_valid, 0);
        chk(vmax == 1, "R5 strobe max run", vmax, 1);
        chk(cs_bad == 0, "R3 start only under select", cs_bad, 0);
    endtask

    task automatic do_timeout();
        int n, rdcnt, v0;
        resp_en = 0;
        v0 = vcount;
        conv_req = 1'b1;
        step();
        conv_req = 1'b0;
        n = 0; rdcnt = 0;
        while (!conv_err && n < 200) begin
            if (!adc_rd_n) rdcnt++;
            step();
            n++;
        end
        chk(conv_err == 1'b1, "R7 timeout error pulse", conv_err, 1);
        chk(rdcnt == TO, "R7 waiting length", rdcnt, TO);
        chk(dout_valid == 1'b0, "R7 no strobe on error", dout_valid, 0);
        chk(ready == 1'b1, "R7 ready after error", ready, 1);
        chk(adc_cs_n == 1'b1, "R7 select released", adc_cs_n, 1);
        step();
        chk(conv_err == 1'b0, "R7 error single cycle", conv_err, 0);
        chk(vcount == v0, "R7 no data strobe", vcount - v0, 0);
        resp_en = 1;
    endtask

    task automatic do_pd(input bit deep, input int wake_n);
        int f0, cnt, bad;
        pd_req  = 1'b1;
        pd_deep = deep;
        step();
        pd_req = 1'b0;
        chk(adc_shdn_n == 1'b1, "R8 mode set before shutdown", adc_shdn_n, 1);
        chk(adc_cs_n == deep, "R8 select level picks mode", adc_cs_n, deep);
        step();
        chk(adc_shdn_n == 1'b0, "R8 shutdown asserted", adc_shdn_n, 0);
        chk(adc_cs_n == deep, "R8 mode level at shutdown", adc_cs_n, deep);
        chk(powered_down == 1'b1, "R8 powered_down flag", powered_down, 1);
        f0 = falls;
        conv_req = 1'b1;
        pd_deep  = ~deep;
        repeat (5) step();
        conv_req = 1'b0;
        chk(falls == f0, "R8 request ignored in power-down", falls - f0, 0);
        chk(adc_cs_n == deep && adc_shdn_n == 1'b0, "R8 mode held", adc_cs_n, deep);
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        cnt = 0; bad = 0;
        while (!ready && cnt < SW + 50) begin
            cnt++;
            if (!adc_shdn_n) bad++;
            conv_req = 1'b1;
            step();
        end
        conv_req = 1'b0;
        chk(cnt == wake_n, "R9 wake-up delay", cnt, wake_n);
        chk(bad == 0, "R9 shutdown released", bad, 0);
        chk(falls == f0, "R9 request ignored during wake-up", falls - f0, 0);
        chk(powered_down == 1'b0, "R9 powered_down cleared", powered_down, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(adc_cs_n && adc_start_n && adc_rd_n && adc_shdn_n, "R1 pins idle after reset",
            {adc_cs_n, adc_start_n, adc_rd_n, adc_shdn_n}, 15);
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        chk(!dout_valid && !conv_err && !powered_down, "R1 flags clear after reset",
            {dout_valid, conv_err, powered_down}, 0);

        do_conv(6, 12'h000, 1'b0);
        do_conv(7, 12'hFFF, 1'b0);
        for (int len = 6; len < 14; len++) begin
            for (int k = 0; k < 4; k++) begin
                do_conv(len, DW'((len * 389 + k * 1021 + 7) % 4096), (k == 2));
                repeat (k) step();
            end
        end

        do_timeout();
        do_conv(9, 12'h5A3, 1'b0);

        do_pd(1'b0, NW);
        do_conv(8, 12'h3C6, 1'b0);
        do_pd(1'b1, SW);
        do_conv(10, 12'hA51, 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule